// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read-side timing engine for a word-wide memory that can serve synchronous bursts. A host holds chip enable high, pulses an active-low address strobe while presenting a start address, and then waits a programmable number of clock edges. Once that latency has run out, the block produces one word per clock. The word order is set by the configuration register: a continuous increment, or a linear sequence that wraps inside an aligned group of 8 or 16 words.

A ready output tells the host when data is valid. Ready either coincides with each valid word or leads it by one clock. A data-valid strobe marks every word that is presented. The storage array is modelled as a fixed function of the word address, so the outputs can be checked.

The configuration register is loaded from a 20-bit word through a write strobe. A mode bit in that word turns bursting off. When bursting is off, the strobe produces no data at all.

Top module: `burst_rd_seq`

## Requirements
- R1: While reset is asserted and after it is released, `dvalid_o` and `rdy_o` are low. The reset configuration is: bursting off, ready aligned, burst code 000, wait code 1001. With that configuration an address strobe produces no valid word.
- R2: When `cfg_we_i` is high on a rising edge, the register loads these fields of `cfg_word_i`: bit 19 enables bursting (1 = burst, 0 = asynchronous), bit 18 selects the ready lead (1 = lead), bits 17:15 hold the burst code, and bits 14:11 hold the wait code. Bits 10:0 are ignored.
- R3: With bit 19 cleared, `dvalid_o` and `rdy_o` stay low whatever the strobe does.
- R4: Edge 1 is the first rising edge at which `stb_ni` is sampled high after it was sampled low. Edge 0 is the last low sample, and it captures `addr_i`. For wait code n, the first word is on the outputs after edge n+3, so a host sampling at edge n+4 sees it.
- R5: Wait codes 1100 to 1111 give the same latency as 1011 (first word sampled at edge 15).
- R6: With the ready lead off, `rdy_o` is high in exactly the cycles in which `dvalid_o` is high.
- R7: With the ready lead on, `rdy_o` is high in exactly the cycles that precede a cycle in which `dvalid_o` is high.
- R8: Burst code 001 gives addresses that step by one inside the aligned 8-word group and wrap to its first word. Starting at offset 2, the order is 2,3,4,5,6,7,0,1.
- R9: Burst code 010 gives the same behaviour inside an aligned 16-word group. Starting at offset 1, the order is 1 through F, then 0.
- R10: Burst code 000, and the reserved codes 011 to 111, step the address by one on every word (modulo 2^20) with no boundary.
- R11: A wrapped burst presents exactly 8 or 16 words. After that, `dvalid_o` and `rdy_o` stay low until the next strobe.
- R12: When `ce_i` is low at a rising edge, `dvalid_o` and `rdy_o` are low after that edge. While `ce_i` is low, the strobe is ignored.
- R13: Whenever `dvalid_o` is high, `data_o` equals `addr_o[15:0]` XOR `addr_o[19:16]` (zero-extended) XOR 16'h5A3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_i | input | 1 | Chip enable, active high |
| stb_ni | input | 1 | Address strobe, active low |
| addr_i | input | 20 | Start word address |
| cfg_we_i | input | 1 | Configuration register load strobe |
| cfg_word_i | input | 20 | Configuration word |
| rdy_o | output | 1 | Ready to the host |
| dvalid_o | output | 1 | Marks a valid word |
| addr_o | output | 20 | Word address of the current word |
| data_o | output | 16 | Modelled array data for `addr_o` |

## Verification
Each burst is traced by its edge index j, counted from the first rising edge with the strobe high. For every j, the bench works out whether a word is due (j from n+3 up to n+2+N for wrapped bursts), which word it is (k = j-(n+3)), and whether ready is due, which is the word predicate at j+1 when the lead is on. Outputs are sampled at the falling edge that follows each rising edge, so every registered result is read exactly one half-period after the edge that produced it. An abort is judged after the single edge that follows the drop of chip enable. The quiet cases are watched for twenty cycles.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

  // configuration word geometry
  localparam int CFG_W     = 20;
  localparam int MODE_BIT  = 19;
  localparam int LEAD_BIT  = 18;
  localparam int LEN_HI    = 17;
  localparam int LEN_LO    = 15;
  localparam int WAIT_HI   = 14;
  localparam int WAIT_LO   = 11;
  localparam int LEN_W     = LEN_HI - LEN_LO + 1;
  localparam int WAIT_W    = WAIT_HI - WAIT_LO + 1;

  // latency / word counters
  localparam int CNT_W      = 4;
  localparam int WAIT_CLAMP = 11;

  // burst codes
  localparam logic [LEN_W-1:0] BL_CONT   = 3'b000;
  localparam logic [LEN_W-1:0] BL_WRAP8  = 3'b001;
  localparam logic [LEN_W-1:0] BL_WRAP16 = 3'b010;

  localparam int GRP8_BITS  = 3;
  localparam int GRP16_BITS = 4;

  typedef struct packed {
    logic              rd_sync;
    logic              rdy_lead;
    logic [LEN_W-1:0]  blen;
    logic [WAIT_W-1:0] wcode;
  } cfg_t;

  localparam cfg_t CFG_RST = '{rd_sync: 1'b0, rdy_lead: 1'b0,
                               blen: BL_CONT, wcode: 4'b1001};

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_BURST = 2'd3
  } seq_st_e;

  // countdown preload: first word leaves the block on edge (code+3)
  function automatic logic [CNT_W-1:0] lat_preload(input logic [WAIT_W-1:0] code);
    logic [CNT_W-1:0] c;
    c = (code > WAIT_W'(WAIT_CLAMP)) ? CNT_W'(WAIT_CLAMP) : CNT_W'(code);
    return c + CNT_W'(1);
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_rd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] word_i,
  output cfg_t             cfg_o
);

  cfg_t cfg_d, cfg_q;
  logic cfg_unused;

  assign cfg_unused = ^word_i[WAIT_LO-1:0];

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) begin
      cfg_d.rd_sync  = word_i[MODE_BIT];
      cfg_d.rdy_lead = word_i[LEAD_BIT];
      cfg_d.blen     = word_i[LEN_HI:LEN_LO];
      cfg_d.wcode    = word_i[WAIT_HI:WAIT_LO];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/burst_timing.sv
module burst_timing
  import burst_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              stb_ni,
  input  logic              rd_sync_i,
  input  logic              rdy_lead_i,
  input  logic [LEN_W-1:0]  blen_i,
  input  logic [WAIT_W-1:0] wcode_i,
  output logic              cap_en_o,
  output logic              adv_en_o,
  output logic              dvalid_o,
  output logic              rdy_o
);

  seq_st_e          st_d, st_q;
  logic [CNT_W-1:0] lat_d, lat_q;
  logic [CNT_W-1:0] wcnt_d, wcnt_q;
  logic             wrap8, wrap16, wrapped, last_word, active;

  assign wrap8     = (blen_i == BL_WRAP8);
  assign wrap16    = (blen_i == BL_WRAP16);
  assign wrapped   = wrap8 | wrap16;
  assign last_word = (wrap8  && wcnt_q == CNT_W'(7)) ||
                     (wrap16 && wcnt_q == CNT_W'(15));
  assign active    = ce_i & rd_sync_i;

  // next state
  always_comb begin
    st_d   = st_q;
    lat_d  = lat_q;
    wcnt_d = wcnt_q;
    if (!active) begin
      st_d = ST_IDLE;
    end else if (!stb_ni) begin
      st_d = ST_ADDR;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          st_d  = ST_WAIT;
          lat_d = lat_preload(wcode_i);
        end
        ST_WAIT: begin
          if (lat_q == '0) begin
            st_d   = ST_BURST;
            wcnt_d = '0;
          end else begin
            lat_d = lat_q - CNT_W'(1);
          end
        end
        ST_BURST: begin
          if (last_word)    st_d   = ST_IDLE;
          else if (wrapped) wcnt_d = wcnt_q + CNT_W'(1);
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      lat_q  <= '0;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      lat_q  <= lat_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign cap_en_o = active & ~stb_ni;
  assign adv_en_o = active & stb_ni & (st_q == ST_BURST) & ~last_word;
  assign dvalid_o = (st_q == ST_BURST);

  always_comb begin
    if (rdy_lead_i)
      rdy_o = ((st_q == ST_WAIT) && lat_q == '0) || ((st_q == ST_BURST) && !last_word);
    else
      rdy_o = (st_q == ST_BURST);
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_rd_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic             adv_en_i,
  input  logic [AW-1:0]    start_i,
  input  logic [LEN_W-1:0] blen_i,
  output logic [AW-1:0]    addr_o
);

  logic [AW-1:0] addr_d, addr_q, inc, mask;
  logic          cont, wrap16;

  assign wrap16 = (blen_i == BL_WRAP16);
  assign cont   = ~((blen_i == BL_WRAP8) | wrap16);

  // per-bit select: bits inside the wrap group take the incremented value
  for (genvar gi = 0; gi < AW; gi++) begin : g_mask
    if (gi < GRP8_BITS) begin : g_low
      assign mask[gi] = 1'b1;
    end else if (gi < GRP16_BITS) begin : g_mid
      assign mask[gi] = cont | wrap16;
    end else begin : g_high
      assign mask[gi] = cont;
    end
  end

  assign inc = addr_q + AW'(1);

  always_comb begin
    addr_d = addr_q;
    if (cap_en_i)      addr_d = start_i;
    else if (adv_en_i) addr_d = (addr_q & ~mask) | (inc & mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import burst_rd_pkg::*;
#(
  parameter int             AW   = 20,
  parameter int             DW   = 16,
  parameter logic [DW-1:0]  SALT = 16'h5A3C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             stb_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_word_i,
  output logic             rdy_o,
  output logic             dvalid_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    data_o
);

  logic [1:0]        rsync_q;
  logic              rst_n_int;
  cfg_t              cfg;
  logic              cfg_sync, cfg_lead;
  logic [LEN_W-1:0]  cfg_blen;
  logic [WAIT_W-1:0] cfg_wcode;
  logic              cap_en, adv_en;
  logic [AW-1:0]     cur_addr;

  // reset: asserted at once, released on the second edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int = rsync_q[1];

  burst_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .we_i   (cfg_we_i),
    .word_i (cfg_word_i),
    .cfg_o  (cfg)
  );

  assign cfg_sync  = cfg.rd_sync;
  assign cfg_lead  = cfg.rdy_lead;
  assign cfg_blen  = cfg.blen;
  assign cfg_wcode = cfg.wcode;

  burst_timing u_tim (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .ce_i       (ce_i),
    .stb_ni     (stb_ni),
    .rd_sync_i  (cfg_sync),
    .rdy_lead_i (cfg_lead),
    .blen_i     (cfg_blen),
    .wcode_i    (cfg_wcode),
    .cap_en_o   (cap_en),
    .adv_en_o   (adv_en),
    .dvalid_o   (dvalid_o),
    .rdy_o      (rdy_o)
  );

  burst_addr_gen #(.AW(AW)) u_agen (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .cap_en_i (cap_en),
    .adv_en_i (adv_en),
    .start_i  (addr_i),
    .blen_i   (cfg_blen),
    .addr_o   (cur_addr)
  );

  // array model: folded address with a fixed salt
  assign addr_o = cur_addr;
  assign data_o = DW'(cur_addr) ^ DW'(cur_addr >> DW) ^ SALT;

endmodule

// File: rtl/burst_rd_seq_chk.sv
module burst_rd_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce,
  input logic          stb_n,
  input logic          cfg_we,
  input logic          rd_sync,
  input logic          rdy_lead,
  input logic [2:0]    blen,
  input logic          dvalid,
  input logic          rdy,
  input logic [AW-1:0] addr
);

  logic cont_code;
  assign cont_code = (blen != 3'b001) && (blen != 3'b010);

  AST_CE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> (!dvalid && !rdy)); // R12

  AST_ASYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sync |=> (!dvalid && !rdy)); // R3

  AST_RDY_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_lead && rdy && ce && stb_n && rd_sync && !cfg_we) |=> dvalid); // R7

  AST_WORD_PRECEDED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dvalid) && $past(rdy_lead) && !$past(cfg_we)) |-> $past(rdy)); // R7

  AST_WRAP8_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && $past(dvalid) && blen == 3'b001 && !$past(cfg_we))
      |-> (addr[AW-1:3] == $past(addr[AW-1:3]))); // R8

  AST_WRAP16_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && $past(dvalid) && blen == 3'b010 && !$past(cfg_we))
      |-> (addr[AW-1:4] == $past(addr[AW-1:4]))); // R9

  AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && $past(dvalid) && cont_code && !$past(cfg_we))
      |-> (addr == $past(addr) + AW'(1))); // R10

endmodule

bind burst_rd_seq burst_rd_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .ce       (ce_i),
  .stb_n    (stb_ni),
  .cfg_we   (cfg_we_i),
  .rd_sync  (cfg_sync),
  .rdy_lead (cfg_lead),
  .blen     (cfg_blen),
  .dvalid   (dvalid_o),
  .rdy      (rdy_o),
  .addr     (addr_o)
);

// File: tb/test_burst_rd_seq.sv
`timescale 1ns/1ps
module test_burst_rd_seq;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          ce_i;
  logic          stb_ni;
  logic [AW-1:0] addr_i;
  logic          cfg_we_i;
  logic [19:0]   cfg_word_i;
  logic          rdy_o, dvalid_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  burst_rd_seq i_burst_rd_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .stb_ni(stb_ni),
    .addr_i(addr_i), .cfg_we_i(cfg_we_i), .cfg_word_i(cfg_word_i),
    .rdy_o(rdy_o), .dvalid_o(dvalid_o), .addr_o(addr_o), .data_o(data_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  function automatic int lat_of(input int w);
    return ((w > 11) ? 11 : w) + 4;
  endfunction

  function automatic bit word_due(input int j, input int lat, input int len);
    bit wr;
    int n;
    wr = (len == 1) || (len == 2);
    n  = (len == 1) ? 8 : 16;
    return (j >= lat - 1) && (!wr || (j <= lat - 2 + n));
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s, input int len, input int k);
    logic [AW-1:0] a;
    if (len == 1)      a = {s[AW-1:3], 3'(s[2:0] + 3'(k))};
    else if (len == 2) a = {s[AW-1:4], 4'(s[3:0] + 4'(k))};
    else               a = s + AW'(k);
    return a;
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] a);
    return a[15:0] ^ {12'h000, a[19:16]} ^ 16'h5A3C;
  endfunction

  // strobe pulse then j-indexed checks; we at the negedge after edge j
  task automatic burst(input bit early, input int len, input int wcode,
                       input logic [AW-1:0] start, input int ncyc,
                       input string lat_tag, input string ord_tag);
    int lat;
    bit dv, rd;
    lat = lat_of(wcode);
    @(negedge clk_i);
    cfg_we_i   = 1'b1;
    cfg_word_i = {1'b1, early, 3'(len), 4'(wcode), 11'h5A5};
    ce_i       = 1'b1;
    stb_ni     = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    stb_ni   = 1'b0;
    addr_i   = start;
    @(negedge clk_i);
    stb_ni = 1'b1;
    addr_i = ~start;
    for (int j = 1; j <= ncyc; j++) begin
      @(negedge clk_i);
      dv = word_due(j, lat, len);
      rd = early ? word_due(j + 1, lat, len) : dv;
      check({lat_tag, " R2 R11 dvalid"}, 32'(dvalid_o), 32'(dv));
      check(early ? "R7 rdy lead" : "R6 rdy aligned", 32'(rdy_o), 32'(rd));
      if (dv) begin
        check({ord_tag, " addr"}, 32'(addr_o), 32'(exp_addr(start, len, j - (lat - 1))));
        check("R13 data", 32'(data_o), 32'(exp_data(addr_o)));
      end
    end
  endtask

  task automatic drop_ce();
    ce_i = 1'b0;
    @(negedge clk_i);
    check("R12 abort dvalid", 32'(dvalid_o), 32'd0);
    check("R12 abort rdy", 32'(rdy_o), 32'd0);
  endtask

  task automatic quiet_pulse(input string tag);
    @(negedge clk_i);
    stb_ni = 1'b0;
    addr_i = 20'h00010;
    @(negedge clk_i);
    stb_ni = 1'b1;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk_i);
      check({tag, " dvalid"}, 32'(dvalid_o), 32'd0);
      check({tag, " rdy"}, 32'(rdy_o), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni     = 1'b0;
    ce_i       = 1'b0;
    stb_ni     = 1'b1;
    addr_i     = '0;
    cfg_we_i   = 1'b0;
    cfg_word_i = '0;
    repeat (3) @(negedge clk_i);
    check("R1 reset dvalid", 32'(dvalid_o), 32'd0);
    check("R1 reset rdy", 32'(rdy_o), 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    ce_i = 1'b1;
    quiet_pulse("R1 R3 default async");

    // explicit async mode with other fields set
    @(negedge clk_i);
    cfg_we_i   = 1'b1;
    cfg_word_i = {1'b0, 1'b1, 3'b001, 4'b0000, 11'h0};
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    quiet_pulse("R3 async");

    // directed shapes
    burst(1'b1, 1, 0, 20'h0ABC2, lat_of(0) - 1 + 8 + 2, "R4", "R8");
    burst(1'b0, 2, 5, 20'h12341, lat_of(5) - 1 + 16 + 2, "R4", "R9");
    burst(1'b1, 0, 0, 20'hFFFFC, lat_of(0) - 1 + 10, "R4", "R10");
    drop_ce();
    burst(1'b0, 5, 15, 20'h00FFE, lat_of(15) - 1 + 6, "R5", "R10");
    drop_ce();
    burst(1'b1, 2, 12, 20'h7777F, lat_of(12) - 1 + 16 + 2, "R5", "R9");

    // strobe while chip enable is low
    @(negedge clk_i);
    ce_i = 1'b0;
    quiet_pulse("R12 ce low");

    // random bursts
    for (int it = 0; it < 40; it++) begin
      int len, wc, ncyc;
      bit early;
      logic [AW-1:0] st;
      len   = int'($urandom_range(0, 7));
      wc    = int'($urandom_range(0, 15));
      early = 1'($urandom_range(0, 1));
      st    = AW'($urandom);
      if (len == 1)      ncyc = lat_of(wc) - 1 + 8 + 2;
      else if (len == 2) ncyc = lat_of(wc) - 1 + 16 + 2;
      else               ncyc = lat_of(wc) - 1 + int'($urandom_range(3, 24));
      burst(early, len, wc, st, ncyc, (wc > 11) ? "R5" : "R4",
            (len == 1) ? "R8" : ((len == 2) ? "R9" : "R10"));
      if (len != 1 && len != 2) drop_ce();
    end
    report();
  end

endmodule